// File: doc/BRIEF.md
# Shared March Diagnosis Sequencer for Distributed Small SRAMs

This block is the central sequencer of a built-in diagnosis scheme in which one controller serves many small SRAMs of mixed depth and width. It is sized for the deepest memory (2^ADDR_W words) and the widest one (DATA_W bits). Every memory has a local wrapper that holds a serial-in pattern register, a local address counter and a capture/shift response register. The sequencer drives these wrappers over a few global wires: one serial background bit with its shift strobe, address clear/step/direction strobes, read and write strobes, a retention-test mode line and a single capture/shift select.

The diagnosis is a March C- style run followed by groups of elements that use extra data backgrounds. There is one group per bit of ceil(log2 DATA_W), and together they reach intra-word and column-decoder faults. Each element follows the same rhythm. The sequencer first shifts the element's write pattern out to every wrapper, MSB first. It then sweeps every address of the deepest memory exactly once. At each address a read is captured into the wrapper and shifted back one bit per cycle while the memory stays idle, and only then is the write issued. Retention faults are covered without any pause. In the first two read-write elements, each normal write is preceded by two writes issued with the retention-test mode line high; in those cycles the wrappers suppress bitline precharge. Response comparison and the memory-local address counters sit outside this block.

Top module: `march_diag_ctrl`

## Requirements
- R1: While reset is asserted, and in the idle state after release, every strobe output and `done` are 0 and `elem_idx` is 0.
- R2: A high `start` sampled in idle or done begins a run at element 0. The first cycle after the sampling edge is a background shift cycle. `start` has no effect while a run is in progress.
- R3: Each element opens with exactly DATA_W cycles of `bg_shift`. In these cycles `bg_bit` carries the element's pattern from bit DATA_W-1 down to bit 0, `addr_clr` is high, and no read, write or step is issued.
- R4: Elements come in this fixed order, with B0 = all zeros. E0 ascending write B0. E1 ascending read then write ~B0. E2 ascending read then write B0. E3 descending read then write ~B0. E4 descending read then write B0. E5 ascending read only. Then, for k = 1 to ceil(log2 DATA_W), three elements: write Bk, read then write ~Bk, read only. Bit i of Bk is bit (k-1) of i. The delivered pattern is the element's write value, or for a read-only element the value expected back.
- R5: At each address of an element that reads, one `mem_rd` cycle (with `scan_sel` low) is followed by exactly DATA_W cycles with `scan_sel` high and no memory access. Any writes for that address come after these cycles.
- R6: In elements E1 and E2 only, each normal write is immediately preceded by exactly two write cycles with `ret_mode` high. `ret_mode` is never high outside a write cycle.
- R7: Each element issues exactly 2^ADDR_W `addr_step` pulses, one in the last cycle of each address. `addr_down` is 1 for E3 and E4 and 0 otherwise.
- R8: An element lasts DATA_W + 2^ADDR_W*(r*(1+DATA_W) + 2*t + w) + 1 cycles, where r, w and t are 1 when the element reads, writes or uses retention writes.
- R9: After the last element, `done` rises and stays high with no strobes issued until a new `start`.
- R10: A wrapper that keeps only the last w bits shifted in ends up holding bits w-1:0 of the pattern. A fault-free memory therefore returns the last written pattern, truncated to its width, at every read.
- R11: At most one of `bg_shift`, `mem_rd`, `mem_wr` and `scan_sel` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a diagnosis run |
| bg_bit | output | 1 | Serial background bit, MSB first |
| bg_shift | output | 1 | Shift strobe for the wrapper pattern registers |
| addr_clr | output | 1 | Preset local address counters to their sweep start |
| addr_down | output | 1 | Sweep direction: 1 descending |
| addr_step | output | 1 | Advance local address counters |
| mem_rd | output | 1 | Read and capture into the response register |
| mem_wr | output | 1 | Write the held pattern |
| ret_mode | output | 1 | Retention-test write cycle, precharge disabled |
| scan_sel | output | 1 | Capture/shift select: 1 shifts response registers |
| elem_idx | output | $clog2(6+3*$clog2(DATA_W)) | Current element index |
| done | output | 1 | Run complete |

## Verification
The bench builds the block with DATA_W = 8 and ADDR_W = 3. This gives fifteen elements, including backgrounds 0xAA, 0xCC and 0xF0, while keeping each sweep short enough for several complete runs. It attaches two behavioural wrappers of depth 8: one 8 bits wide and one 3 bits wide. The narrow one shows that MSB-first delivery leaves the low pattern bits in a smaller memory. Descending sweeps wrap the 3-bit local counters from 7 downward, and runs start from idle, start from done, hold `start` high throughout, see a stray `start` mid-run and are cut by a mid-run reset.

// File: rtl/march_diag_pkg.sv
package march_diag_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_BG,
    ST_RUN_ELEM,
    ST_RET_WR,
    ST_CAPTURE,
    ST_SHIFT_RESP,
    ST_NEXT_ELEM,
    ST_DONE
  } diag_state_e;

  // Operations performed at every address of one element
  typedef struct packed {
    logic rd;
    logic wr;
    logic down;
    logic ret;
  } elem_ops_t;

  localparam int unsigned BASE_ELEMS   = 6;
  localparam int unsigned ELEMS_PER_BG = 3;
  localparam int unsigned RET_WRITES   = 2;

  function automatic int unsigned elem_count(input int unsigned width);
    return BASE_ELEMS + ELEMS_PER_BG * $clog2(width);
  endfunction

endpackage

// File: rtl/march_elem_rom.sv
module march_elem_rom
  import march_diag_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx,
  output elem_ops_t         ops,
  output logic [DATA_W-1:0] pat
);

  always_comb begin
    int unsigned e;
    int unsigned rel;
    int unsigned grp;
    int unsigned sub;
    logic [DATA_W-1:0] bg;
    e   = 32'(idx);
    rel = 0;
    grp = 0;
    sub = 0;
    ops = '0;
    pat = '0;
    bg  = '0;
    if (e < BASE_ELEMS) begin
      // solid background, March C- body
      case (e)
        0: begin ops.wr = 1'b1; pat = bg; end
        1: begin ops.rd = 1'b1; ops.wr = 1'b1; ops.ret = 1'b1; pat = ~bg; end
        2: begin ops.rd = 1'b1; ops.wr = 1'b1; ops.ret = 1'b1; pat = bg; end
        3: begin ops.rd = 1'b1; ops.wr = 1'b1; ops.down = 1'b1; pat = ~bg; end
        4: begin ops.rd = 1'b1; ops.wr = 1'b1; ops.down = 1'b1; pat = bg; end
        default: begin ops.rd = 1'b1; pat = bg; end
      endcase
    end else begin
      rel = e - BASE_ELEMS;
      grp = rel / ELEMS_PER_BG;
      sub = rel % ELEMS_PER_BG;
      // bit groups of size 2**grp alternate
      for (int i = 0; i < int'(DATA_W); i++) begin
        bg[i] = ((i >> grp) & 1) != 0;
      end
      case (sub)
        0: begin ops.wr = 1'b1; pat = bg; end
        1: begin ops.rd = 1'b1; ops.wr = 1'b1; pat = ~bg; end
        default: begin ops.rd = 1'b1; pat = ~bg; end
      endcase
    end
  end

endmodule

// File: rtl/bg_serializer.sv
module bg_serializer #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] pat,
  output logic              ser_bit
);

  logic [DATA_W-1:0] sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (load) begin
      sreg_q <= pat;
    end else if (shift) begin
      sreg_q <= sreg_q << 1;
    end
  end

  // most significant bit leaves first
  assign ser_bit = sreg_q[DATA_W-1];

endmodule

// File: rtl/addr_sweep_cnt.sv
module addr_sweep_cnt #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == {ADDR_W{1'b1}});

endmodule

// File: rtl/march_diag_ctrl.sv
module march_diag_ctrl
  import march_diag_pkg::*;
#(
  parameter  int unsigned DATA_W = 16,
  parameter  int unsigned ADDR_W = 6,
  localparam int unsigned NELEM  = elem_count(DATA_W),
  localparam int unsigned IDX_W  = (NELEM > 1) ? $clog2(NELEM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             bg_bit,
  output logic             bg_shift,
  output logic             addr_clr,
  output logic             addr_down,
  output logic             addr_step,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ret_mode,
  output logic             scan_sel,
  output logic [IDX_W-1:0] elem_idx,
  output logic             done
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_BG_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_RET_LAST = CNT_W'(RET_WRITES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST     = IDX_W'(NELEM - 1);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  diag_state_e       state_q, state_d;
  logic [IDX_W-1:0]  elem_q, elem_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ser_load;
  logic              op_end;
  logic              sweep_last;
  elem_ops_t         ops;
  logic [DATA_W-1:0] pat;

  march_elem_rom #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rom (
    .idx (elem_d),
    .ops (ops),
    .pat (pat)
  );

  bg_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (ser_load),
    .shift   (bg_shift),
    .pat     (pat),
    .ser_bit (bg_bit)
  );

  addr_sweep_cnt #(.ADDR_W(ADDR_W)) u_sweep (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (addr_clr),
    .step  (addr_step),
    .last  (sweep_last)
  );

  always_comb begin
    state_d   = state_q;
    elem_d    = elem_q;
    cnt_d     = cnt_q;
    ser_load  = 1'b0;
    op_end    = 1'b0;
    bg_shift  = 1'b0;
    addr_clr  = 1'b0;
    addr_step = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    ret_mode  = 1'b0;
    scan_sel  = 1'b0;
    done      = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        done = (state_q == ST_DONE);
        if (start) begin
          state_d  = ST_LOAD_BG;
          elem_d   = '0;
          cnt_d    = '0;
          ser_load = 1'b1;
        end
      end
      ST_LOAD_BG: begin
        bg_shift = 1'b1;
        addr_clr = 1'b1;
        if (cnt_q == CNT_BG_LAST) begin
          cnt_d   = '0;
          state_d = ops.rd ? ST_CAPTURE : ST_RUN_ELEM;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CAPTURE: begin
        mem_rd  = 1'b1;
        cnt_d   = '0;
        state_d = ST_SHIFT_RESP;
      end
      ST_SHIFT_RESP: begin
        scan_sel = 1'b1;
        if (cnt_q == CNT_BG_LAST) begin
          cnt_d = '0;
          if (!ops.wr) begin
            op_end = 1'b1;
          end else begin
            state_d = ops.ret ? ST_RET_WR : ST_RUN_ELEM;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RET_WR: begin
        mem_wr   = 1'b1;
        ret_mode = 1'b1;
        if (cnt_q == CNT_RET_LAST) begin
          cnt_d   = '0;
          state_d = ST_RUN_ELEM;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN_ELEM: begin
        mem_wr = 1'b1;
        op_end = 1'b1;
      end
      ST_NEXT_ELEM: begin
        if (elem_q == IDX_LAST) begin
          state_d = ST_DONE;
        end else begin
          elem_d   = elem_q + 1'b1;
          cnt_d    = '0;
          ser_load = 1'b1;
          state_d  = ST_LOAD_BG;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (op_end) begin
      addr_step = 1'b1;
      if (sweep_last) begin
        state_d = ST_NEXT_ELEM;
      end else begin
        state_d = ops.rd ? ST_CAPTURE : ST_RUN_ELEM;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      cnt_q   <= cnt_d;
    end
  end

  assign addr_down = ops.down;
  assign elem_idx  = elem_q;

endmodule

// File: rtl/march_diag_chk.sv
module march_diag_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic bg_shift,
  input logic addr_step,
  input logic mem_rd,
  input logic mem_wr,
  input logic ret_mode,
  input logic scan_sel,
  input logic done
);

  assert_one_global_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bg_shift, mem_rd, mem_wr, scan_sel}));

  assert_ret_only_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_mode |-> mem_wr);

  assert_ret_pair_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ret_mode) |-> ($past(ret_mode, 2) && mem_wr));

  assert_capture_then_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> scan_sel);

  assert_no_step_in_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bg_shift |-> !addr_step);

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bg_shift || mem_rd || mem_wr || scan_sel || addr_step));

endmodule

bind march_diag_ctrl march_diag_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .bg_shift  (bg_shift),
  .addr_step (addr_step),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .ret_mode  (ret_mode),
  .scan_sel  (scan_sel),
  .done      (done)
);

// File: tb/sim_march_diag_ctrl.sv
module sim_march_diag_ctrl;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NW      = 3;
  localparam int LG      = $clog2(DATA_W);
  localparam int NELEM   = 6 + 3 * LG;
  localparam int IDX_W   = $clog2(NELEM);
  localparam int CLK_PER = 10;

  logic clk, rst_n, start;
  logic bg_bit, bg_shift, addr_clr, addr_down, addr_step;
  logic mem_rd, mem_wr, ret_mode, scan_sel, done;
  logic [IDX_W-1:0] elem_idx;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  march_diag_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bg_bit(bg_bit), .bg_shift(bg_shift),
    .addr_clr(addr_clr), .addr_down(addr_down), .addr_step(addr_step),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ret_mode(ret_mode), .scan_sel(scan_sel),
    .elem_idx(elem_idx), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  // expected element table, built from the requirement text
  bit              x_rd [NELEM];
  bit              x_wr [NELEM];
  bit              x_dn [NELEM];
  bit              x_rt [NELEM];
  logic [DATA_W-1:0] x_pat [NELEM];
  int              x_len [NELEM];
  int              x_total;

  function automatic logic [DATA_W-1:0] bg_word(input int k);
    logic [DATA_W-1:0] w;
    w = '0;
    if (k > 0)
      for (int i = 0; i < DATA_W; i++) w[i] = ((i / (1 << (k - 1))) % 2) == 1;
    return w;
  endfunction

  initial begin
    int n;
    n = 0;
    x_total = 0;
    // E0..E5
    x_rd[0]=0; x_wr[0]=1; x_dn[0]=0; x_rt[0]=0; x_pat[0]='0;
    x_rd[1]=1; x_wr[1]=1; x_dn[1]=0; x_rt[1]=1; x_pat[1]='1;
    x_rd[2]=1; x_wr[2]=1; x_dn[2]=0; x_rt[2]=1; x_pat[2]='0;
    x_rd[3]=1; x_wr[3]=1; x_dn[3]=1; x_rt[3]=0; x_pat[3]='1;
    x_rd[4]=1; x_wr[4]=1; x_dn[4]=1; x_rt[4]=0; x_pat[4]='0;
    x_rd[5]=1; x_wr[5]=0; x_dn[5]=0; x_rt[5]=0; x_pat[5]='0;
    n = 6;
    for (int k = 1; k <= LG; k++) begin
      x_rd[n]=0; x_wr[n]=1; x_dn[n]=0; x_rt[n]=0; x_pat[n]=bg_word(k);  n++;
      x_rd[n]=1; x_wr[n]=1; x_dn[n]=0; x_rt[n]=0; x_pat[n]=~bg_word(k); n++;
      x_rd[n]=1; x_wr[n]=0; x_dn[n]=0; x_rt[n]=0; x_pat[n]=~bg_word(k); n++;
    end
    for (int e = 0; e < NELEM; e++) begin
      x_len[e] = DATA_W + 1 + DEPTH * ((x_rd[e] ? 1 + DATA_W : 0) + (x_rt[e] ? 2 : 0) + (x_wr[e] ? 1 : 0));
      x_total += x_len[e];
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural wrappers: one full width, one 3 bits wide, both full depth
  logic [DATA_W-1:0] mem_w [DEPTH];
  logic [NW-1:0]     mem_n [DEPTH];
  logic [DATA_W-1:0] spc_w, psc_w;
  logic [NW-1:0]     spc_n, psc_n;
  logic [ADDR_W-1:0] la;

  always @(posedge clk) begin
    if (bg_shift) begin
      spc_w <= {spc_w[DATA_W-2:0], bg_bit};
      spc_n <= {spc_n[NW-2:0], bg_bit};
    end
    if (addr_clr) la <= addr_down ? '1 : '0;
    else if (addr_step) la <= addr_down ? la - 1'b1 : la + 1'b1;
    if (mem_wr) begin
      mem_w[la] <= spc_w;
      mem_n[la] <= spc_n;
    end
    if (mem_rd && !scan_sel) begin
      psc_w <= mem_w[la];
      psc_n <= mem_n[la];
    end else if (scan_sel) begin
      psc_w <= psc_w >> 1;
      psc_n <= psc_n >> 1;
    end
  end

  // element monitor
  bit in_elem = 0;
  bit prev_bg = 0, prev_scan = 0;
  int cur = 0, exp_next = 0;
  int cyc, nbg, caps, shc, rets, wrs, steps, dnerr, runerr, rderr, run_len, bitpos;
  logic [DATA_W-1:0] bgw, rw, last_wr;
  logic [NW-1:0] rn;

  task automatic finalize();
    check(cyc == x_len[cur], $sformatf("R8 length E%0d", cur), cyc, x_len[cur]);
    check(nbg == DATA_W && bgw == x_pat[cur], $sformatf("R3 R4 pattern E%0d", cur), bgw, x_pat[cur]);
    check(caps == (x_rd[cur] ? DEPTH : 0), $sformatf("R5 captures E%0d", cur), caps, x_rd[cur] ? DEPTH : 0);
    check(shc == (x_rd[cur] ? DEPTH * DATA_W : 0) && runerr == 0, $sformatf("R5 shift E%0d", cur), shc, x_rd[cur] ? DEPTH * DATA_W : 0);
    check(rets == (x_rt[cur] ? 2 * DEPTH : 0), $sformatf("R6 retention E%0d", cur), rets, x_rt[cur] ? 2 * DEPTH : 0);
    check(wrs == (x_wr[cur] ? DEPTH : 0), $sformatf("R4 writes E%0d", cur), wrs, x_wr[cur] ? DEPTH : 0);
    check(steps == DEPTH && dnerr == 0, $sformatf("R7 steps E%0d", cur), steps, DEPTH);
    check(rderr == 0, $sformatf("R10 readback E%0d", cur), rderr, 0);
    if (x_wr[cur]) last_wr = x_pat[cur];
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      in_elem = 0; exp_next = 0; prev_bg = 0; prev_scan = 0;
    end else begin
      if (in_elem && done) begin
        finalize();
        check(exp_next == NELEM, "R4 element count", exp_next, NELEM);
        in_elem = 0; exp_next = 0;
      end
      if (bg_shift && !prev_bg) begin
        if (in_elem) finalize();
        check(32'(elem_idx) == exp_next, "R4 element index", elem_idx, exp_next);
        cur = exp_next; exp_next++; in_elem = 1;
        cyc = 0; nbg = 0; caps = 0; shc = 0; rets = 0; wrs = 0; steps = 0;
        dnerr = 0; runerr = 0; rderr = 0; run_len = 0; bitpos = 0; bgw = '0;
      end
      if (in_elem) begin
        cyc++;
        if (bg_shift) begin
          bgw = {bgw[DATA_W-2:0], bg_bit}; nbg++;
          if (!addr_clr || mem_rd || mem_wr || addr_step) runerr++;
        end
        if (mem_rd) caps++;
        if (scan_sel) begin
          shc++; run_len++;
          rw[bitpos] = psc_w[0];
          if (bitpos < NW) rn[bitpos] = psc_n[0];
          bitpos++;
          if (bitpos == DATA_W) begin
            if (rw != last_wr || rn != last_wr[NW-1:0]) rderr++;
            bitpos = 0;
          end
        end else if (prev_scan) begin
          if (run_len != DATA_W) runerr++;
          run_len = 0;
        end
        if (ret_mode) rets++;
        if (mem_wr && !ret_mode) wrs++;
        if (addr_step) begin
          steps++;
          if (addr_down != x_dn[cur]) dnerr++;
        end
      end
      prev_bg = bg_shift;
      prev_scan = scan_sel;
    end
  end

  function automatic bit quiet();
    return !(bg_shift || addr_clr || addr_step || mem_rd || mem_wr || ret_mode || scan_sel);
  endfunction

  // one run: optional start held throughout, optional stray start pulse
  task automatic run(input string tag, input bit hold, input int glitch_at);
    int cnt;
    cnt = 0;
    @(negedge clk);
    start = 1'b1;
    forever begin
      @(negedge clk);
      if (done && cnt > 0) break;
      if (!hold) start = (cnt == glitch_at);
      cnt++;
      if (cnt > 20000) break;
    end
    start = 1'b0;
    check(done == 1'b1, {"R9 done reached ", tag}, done, 1);
    check(cnt == x_total, {"R2 R8 run length ", tag}, cnt, x_total);
  endtask

  initial begin
    int bad;
    int w;
    void'($urandom(32'd1971));
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(quiet() && !done && elem_idx == '0, "R1 outputs in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(quiet() && !done && elem_idx == '0, "R1 idle after release", done, 0);

    // directed: plain pulse from idle
    run("pulse", 1'b0, -1);
    w = $urandom_range(5, 20);
    bad = 0;
    repeat (w) begin
      @(negedge clk);
      if (!done || !quiet()) bad++;
    end
    check(bad == 0, "R9 done held and quiet", bad, 0);

    // start from done, held high throughout
    run("held", 1'b1, -1);

    // random gap then a stray start mid-run (R2 ignored)
    repeat ($urandom_range(1, 30)) @(negedge clk);
    run("stray", 1'b0, $urandom_range(40, x_total - 40));

    // reset cut in the middle of a run
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat ($urandom_range(30, 600)) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(quiet() && !done && elem_idx == '0, "R1 async reset mid-run", elem_idx, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(quiet() && !done && elem_idx == '0, "R1 idle after mid-run reset", done, 0);

    // final run after reset, with a random stray start
    run("after reset", 1'b0, $urandom_range(40, x_total - 40));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule